// File: doc/BRIEF.md
# Stereo Audio FIFO Polling Sequencer

This block sits between a memory-mapped audio codec FIFO and a sample-processing pipeline. It is a small bus master that runs one fixed loop for as long as it is out of reset. First it reads a status word to learn how much room the codec has for output samples. When both channels have room it writes the left output sample and then the right one, as two separate bus writes. It then reads the status word again, this time to see whether captured input is waiting. When both channels hold input it reads the left and then the right input sample. The loop then starts again.

The pipeline side has no handshake. Each output channel has its own data and valid pair. A valid strobe loads that channel's holding register, and the loop always writes the most recently loaded values. Only the right input sample goes on to the pipeline. It is presented on a data output together with a single-cycle valid strobe. No backpressure is needed, because the system clock runs hundreds of times faster than the audio sample rate.

Top module: `audio_fifo_poll_seq`

## Requirements
- R1: While `rst` is high, neither `bus_rd` nor `bus_wr` is asserted and `cap_valid` is low. The first request after reset is a read of `STATUS_ADDR`.
- R2: A status read in the output phase leads to writes only if both room counts are non-zero. The left room count is in bits [31:24] and the right room count is in bits [23:16]. Otherwise the next request is another status read.
- R3: The left output sample is written to `LEFT_ADDR` and then the right output sample to `RIGHT_ADDR`, as two distinct write transfers in that order.
- R4: Each channel's written value is the data present on the last cycle that channel's valid input was high. The two channels update independently, and both are zero after reset.
- R5: After the right write, the status word is read again. Both channels are read (left at `LEFT_ADDR`, then right at `RIGHT_ADDR`) only if the left input count in bits [15:8] and the right input count in bits [7:0] are both non-zero. Otherwise the loop restarts with the output-phase status read.
- R6: `cap_valid` is high for exactly one cycle. That cycle is the one after the acknowledged right-channel read, and `cap_data` then equals the data returned by that read. Left input data never appears on `cap_data` with `cap_valid`.
- R7: A request keeps its address, direction and write data unchanged until `bus_ack` is seen. Read and write are never asserted together.
- R8: After the right-channel read completes, the next completed transfer is a status read, so every input read phase is followed by a new output phase.
- R9: Any acknowledge latency is tolerated, and the sequence above is kept whatever the number of wait cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | output | ADDR_W | Word address of the current transfer |
| bus_rd | output | 1 | Read request, held until acknowledged |
| bus_wr | output | 1 | Write request, held until acknowledged |
| bus_wdata | output | 32 | Output sample being written |
| bus_rdata | input | 32 | Read data, valid while `bus_ack` is high |
| bus_ack | input | 1 | Transfer acknowledge from the codec FIFO |
| pl_left_data | input | 32 | Left output sample from the pipeline |
| pl_left_valid | input | 1 | Loads `pl_left_data` |
| pl_right_data | input | 32 | Right output sample from the pipeline |
| pl_right_valid | input | 1 | Loads `pl_right_data` |
| cap_data | output | 32 | Captured right input sample |
| cap_valid | output | 1 | One-cycle strobe marking new `cap_data` |

## Verification
The bus outputs are decoded from the state register. A new request therefore appears in the cycle after the acknowledge that completed the previous transfer. The bench's bus model samples each transfer at the falling edge after its acknowledge edge. The capture strobe and its data are registered on the edge that accepts the right-channel read, so they are due exactly one cycle later. The bench checks them at the next falling edge against the transfer it just logged. A holding register loads on the edge after its valid strobe, so the bench waits a settling interval before it compares written values.

// File: rtl/apsq_pkg.sv
package apsq_pkg;

    localparam int BUS_W   = 32;
    localparam int FIELD_W = BUS_W / 4;
    localparam int NUM_CH  = 2;

    typedef struct packed {
        logic [FIELD_W-1:0] tx_left;
        logic [FIELD_W-1:0] tx_right;
        logic [FIELD_W-1:0] rx_left;
        logic [FIELD_W-1:0] rx_right;
    } stat_word_t;

    typedef enum logic [2:0] {
        ST_POLL_TX = 3'd0,
        ST_PUT_L   = 3'd1,
        ST_PUT_R   = 3'd2,
        ST_POLL_RX = 3'd3,
        ST_GET_L   = 3'd4,
        ST_GET_R   = 3'd5
    } seq_state_t;

    typedef enum logic {
        CH_LEFT  = 1'b0,
        CH_RIGHT = 1'b1
    } chan_t;

    function automatic logic field_set(input logic [FIELD_W-1:0] f);
        return |f;
    endfunction

endpackage

// File: rtl/apsq_status_dec.sv
module apsq_status_dec
    import apsq_pkg::*;
(
    input  logic [BUS_W-1:0] word,
    output logic             pair_room,
    output logic             pair_input
);
    stat_word_t s;

    always_comb begin
        s          = stat_word_t'(word);
        pair_room  = field_set(s.tx_left) && field_set(s.tx_right);
        pair_input = field_set(s.rx_left) && field_set(s.rx_right);
    end
endmodule

// File: rtl/apsq_out_latch.sv
module apsq_out_latch
    import apsq_pkg::*;
#(
    parameter int W = BUS_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_CH-1:0][W-1:0] d,
    input  logic [NUM_CH-1:0]        v,
    output logic [NUM_CH-1:0][W-1:0] q
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst)       q[c] <= '0;
            else if (v[c]) q[c] <= d[c];
        end
    end
endmodule

// File: rtl/apsq_fsm.sv
module apsq_fsm
    import apsq_pkg::*;
#(
    parameter int                ADDR_W      = 4,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = 'd1,
    parameter logic [ADDR_W-1:0] LEFT_ADDR   = 'd2,
    parameter logic [ADDR_W-1:0] RIGHT_ADDR  = 'd3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_ack,
    input  logic              pair_room,
    input  logic              pair_input,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic [ADDR_W-1:0] bus_addr,
    output chan_t             wsel,
    output logic              take_right
);
    seq_state_t st, nxt;
    logic       rd_req, wr_req, done;

    always_comb begin
        rd_req = (st == ST_POLL_TX) || (st == ST_POLL_RX) ||
                 (st == ST_GET_L)   || (st == ST_GET_R);
        wr_req = (st == ST_PUT_L) || (st == ST_PUT_R);
        bus_rd = rd_req && !rst;
        bus_wr = wr_req && !rst;
        done   = bus_ack && (bus_rd || bus_wr);
        unique case (st)
            ST_PUT_L, ST_GET_L: bus_addr = LEFT_ADDR;
            ST_PUT_R, ST_GET_R: bus_addr = RIGHT_ADDR;
            default:            bus_addr = STATUS_ADDR;
        endcase
        wsel       = (st == ST_PUT_R) ? CH_RIGHT : CH_LEFT;
        take_right = (st == ST_GET_R) && done;
    end

    always_comb begin
        nxt = st;
        unique case (st)
            ST_POLL_TX: nxt = pair_room  ? ST_PUT_L : ST_POLL_TX;
            ST_PUT_L:   nxt = ST_PUT_R;
            ST_PUT_R:   nxt = ST_POLL_RX;
            ST_POLL_RX: nxt = pair_input ? ST_GET_L : ST_POLL_TX;
            ST_GET_L:   nxt = ST_GET_R;
            ST_GET_R:   nxt = ST_POLL_TX;
            default:    nxt = ST_POLL_TX;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)       st <= ST_POLL_TX;
        else if (done) st <= nxt;
    end
endmodule

// File: rtl/apsq_fwd.sv
module apsq_fwd
    import apsq_pkg::*;
#(
    parameter int W = BUS_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         take,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         dvalid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            dout   <= '0;
            dvalid <= 1'b0;
        end else begin
            dvalid <= take;
            if (take) dout <= din;
        end
    end
endmodule

// File: rtl/audio_fifo_poll_seq.sv
module audio_fifo_poll_seq
    import apsq_pkg::*;
#(
    parameter int                ADDR_W      = 4,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = 'd1,
    parameter logic [ADDR_W-1:0] LEFT_ADDR   = 'd2,
    parameter logic [ADDR_W-1:0] RIGHT_ADDR  = 'd3
) (
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic [BUS_W-1:0]  bus_wdata,
    input  logic [BUS_W-1:0]  bus_rdata,
    input  logic              bus_ack,
    input  logic [BUS_W-1:0]  pl_left_data,
    input  logic              pl_left_valid,
    input  logic [BUS_W-1:0]  pl_right_data,
    input  logic              pl_right_valid,
    output logic [BUS_W-1:0]  cap_data,
    output logic              cap_valid
);
    logic [NUM_CH-1:0][BUS_W-1:0] held;
    logic [NUM_CH-1:0][BUS_W-1:0] pl_d;
    logic [NUM_CH-1:0]            pl_v;
    logic                         pair_room, pair_input, take_right;
    chan_t                        wsel;

    assign pl_d[CH_LEFT]  = pl_left_data;
    assign pl_d[CH_RIGHT] = pl_right_data;
    assign pl_v[CH_LEFT]  = pl_left_valid;
    assign pl_v[CH_RIGHT] = pl_right_valid;

    apsq_out_latch #(.W(BUS_W)) latch_i (
        .clk (clk),
        .rst (rst),
        .d   (pl_d),
        .v   (pl_v),
        .q   (held)
    );

    apsq_status_dec dec_i (
        .word       (bus_rdata),
        .pair_room  (pair_room),
        .pair_input (pair_input)
    );

    apsq_fsm #(
        .ADDR_W      (ADDR_W),
        .STATUS_ADDR (STATUS_ADDR),
        .LEFT_ADDR   (LEFT_ADDR),
        .RIGHT_ADDR  (RIGHT_ADDR)
    ) fsm_i (
        .clk        (clk),
        .rst        (rst),
        .bus_ack    (bus_ack),
        .pair_room  (pair_room),
        .pair_input (pair_input),
        .bus_rd     (bus_rd),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .wsel       (wsel),
        .take_right (take_right)
    );

    assign bus_wdata = held[wsel];

    apsq_fwd #(.W(BUS_W)) fwd_i (
        .clk    (clk),
        .rst    (rst),
        .take   (take_right),
        .din    (bus_rdata),
        .dout   (cap_data),
        .dvalid (cap_valid)
    );
endmodule

// File: rtl/apsq_checker.sv
module apsq_checker
    import apsq_pkg::*;
#(
    parameter int                ADDR_W      = 4,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = 'd1,
    parameter logic [ADDR_W-1:0] LEFT_ADDR   = 'd2,
    parameter logic [ADDR_W-1:0] RIGHT_ADDR  = 'd3
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [BUS_W-1:0]  bus_wdata,
    input logic [BUS_W-1:0]  bus_rdata,
    input logic              bus_ack,
    input logic [BUS_W-1:0]  cap_data,
    input logic              cap_valid
);
    logic stat_done, room_seen, input_seen;
    assign stat_done  = bus_rd && bus_ack && (bus_addr == STATUS_ADDR);
    assign room_seen  = (bus_rdata[31:24] != 8'd0) && (bus_rdata[23:16] != 8'd0);
    assign input_seen = (bus_rdata[15:8] != 8'd0) && (bus_rdata[7:0] != 8'd0);

    // R1: quiet bus while reset is held
    always @(posedge clk)
        if (rst) a_r1_quiet_in_reset: assert (!bus_rd && !bus_wr);

    a_r7_rd_held: assert property (@(posedge clk) disable iff (rst)
        bus_rd && !bus_ack |=> bus_rd && $stable(bus_addr));

    a_r7_wr_held: assert property (@(posedge clk) disable iff (rst)
        bus_wr && !bus_ack |=> bus_wr && $stable(bus_addr) && $stable(bus_wdata));

    a_r7_one_dir: assert property (@(posedge clk) disable iff (rst)
        !(bus_rd && bus_wr));

    a_r3_right_follows_left: assert property (@(posedge clk) disable iff (rst)
        bus_wr && bus_ack && (bus_addr == LEFT_ADDR) |=> bus_wr && (bus_addr == RIGHT_ADDR));

    a_r5_poll_after_put: assert property (@(posedge clk) disable iff (rst)
        bus_wr && bus_ack && (bus_addr == RIGHT_ADDR) |=> bus_rd && (bus_addr == STATUS_ADDR));

    a_r2_repoll_when_idle: assert property (@(posedge clk) disable iff (rst)
        stat_done && !room_seen && !input_seen |=> bus_rd && (bus_addr == STATUS_ADDR));

    a_r8_poll_after_get: assert property (@(posedge clk) disable iff (rst)
        bus_rd && bus_ack && (bus_addr == RIGHT_ADDR) |=> bus_rd && (bus_addr == STATUS_ADDR));

    a_r6_strobe_after_get: assert property (@(posedge clk) disable iff (rst)
        bus_rd && bus_ack && (bus_addr == RIGHT_ADDR) |=> cap_valid && (cap_data == $past(bus_rdata)));

    a_r6_strobe_cause: assert property (@(posedge clk) disable iff (rst)
        cap_valid |-> $past(bus_rd && bus_ack && (bus_addr == RIGHT_ADDR)));

    a_r6_single_cycle: assert property (@(posedge clk) disable iff (rst)
        cap_valid |=> !cap_valid);
endmodule

bind audio_fifo_poll_seq apsq_checker #(
    .ADDR_W      (ADDR_W),
    .STATUS_ADDR (STATUS_ADDR),
    .LEFT_ADDR   (LEFT_ADDR),
    .RIGHT_ADDR  (RIGHT_ADDR)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .bus_ack   (bus_ack),
    .cap_data  (cap_data),
    .cap_valid (cap_valid)
);

// File: tb/audio_fifo_poll_seq_tb.sv
module audio_fifo_poll_seq_tb_top;
    localparam int          AW   = 4;
    localparam logic [3:0]  A_ST = 4'd1;
    localparam logic [3:0]  A_L  = 4'd2;
    localparam logic [3:0]  A_R  = 4'd3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] bus_addr;
    logic          bus_rd, bus_wr;
    logic [31:0]   bus_wdata;
    logic [31:0]   bus_rdata = '0;
    logic          bus_ack = 1'b0;
    logic [31:0]   pl_left_data = '0, pl_right_data = '0;
    logic          pl_left_valid = 1'b0, pl_right_valid = 1'b0;
    logic [31:0]   cap_data;
    logic          cap_valid;

    always #10 clk = ~clk;

    audio_fifo_poll_seq #(.ADDR_W(AW), .STATUS_ADDR(A_ST), .LEFT_ADDR(A_L), .RIGHT_ADDR(A_R)) dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
        .pl_left_data(pl_left_data), .pl_left_valid(pl_left_valid),
        .pl_right_data(pl_right_data), .pl_right_valid(pl_right_valid),
        .cap_data(cap_data), .cap_valid(cap_valid));

    // bus model configuration, driven only by the main sequence
    logic [31:0] tx_stat = '0, rx_stat = '0, rd_l = '0, rd_r = '0;
    int          lat = 0;
    int          clr_gen = 0;

    // bus model and monitor state
    int          seen_gen = 0, wait_cnt = 0;
    logic        rx_phase = 1'b0, last_was_putl = 1'b0, after_get = 1'b0;
    logic        p_rd = 1'b0, p_wr = 1'b0;
    logic [3:0]  p_addr = '0;
    logic [31:0] p_wdata = '0;
    int          put_cnt = 0, cap_cnt = 0, proto_err = 0, order_err = 0, timing_err = 0, r8_err = 0;
    logic [31:0] last_wl = '0, last_wr = '0, last_cap = '0;

    always @(negedge clk) begin
        if (seen_gen != clr_gen) begin
            seen_gen = clr_gen;
            put_cnt = 0; cap_cnt = 0; proto_err = 0; order_err = 0; timing_err = 0; r8_err = 0;
        end
        if (rst) begin
            bus_ack = 1'b0; wait_cnt = 0; rx_phase = 1'b0; last_was_putl = 1'b0; after_get = 1'b0;
        end else begin
            // expected strobe: one cycle after an acknowledged right read (R6)
            if (cap_valid != (bus_ack && p_rd && p_addr == A_R)) timing_err++;
            if (cap_valid) begin
                cap_cnt++; last_cap = cap_data;
                if (cap_data != rd_r) timing_err++;
            end
            if (bus_ack) begin
                if (after_get && !(p_rd && p_addr == A_ST)) r8_err++;
                after_get = 1'b0;
                if (p_wr && p_addr == A_L) begin last_wl = p_wdata; last_was_putl = 1'b1; end
                else if (p_wr && p_addr == A_R) begin
                    if (!last_was_putl) order_err++;
                    last_was_putl = 1'b0; last_wr = p_wdata; put_cnt++; rx_phase = 1'b1;
                end else begin
                    if (last_was_putl) order_err++;
                    if (p_rd && p_addr == A_ST && rx_phase) rx_phase = 1'b0;
                    if (p_rd && p_addr == A_R) after_get = 1'b1;
                end
                bus_ack = 1'b0; wait_cnt = 0;
            end else begin
                if (p_rd || p_wr)
                    if (bus_rd != p_rd || bus_wr != p_wr || bus_addr != p_addr ||
                        (p_wr && bus_wdata != p_wdata)) proto_err++;
                if (bus_rd && bus_wr) proto_err++;
                if (bus_rd || bus_wr) begin
                    if (wait_cnt >= lat) begin
                        bus_ack = 1'b1;
                        if (bus_addr == A_ST)     bus_rdata = rx_phase ? rx_stat : tx_stat;
                        else if (bus_addr == A_L) bus_rdata = rd_l;
                        else                      bus_rdata = rd_r;
                    end else wait_cnt++;
                end
            end
        end
        p_rd = bus_rd; p_wr = bus_wr; p_addr = bus_addr; p_wdata = bus_wdata;
    end

    typedef struct packed {
        logic [31:0] wstat;
        logic [31:0] rstat;
        logic [2:0]  lat;
        logic        push_l;
        logic [31:0] lval;
        logic        push_r;
        logic [31:0] rval;
        logic [31:0] rdl;
        logic [31:0] rdr;
        logic        exp_put;
        logic        exp_cap;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{32'h0101_0000, 32'h0000_0101, 3'd0, 1'b1, 32'h0000_1111, 1'b1, 32'h0000_2222, 32'hA1A1_0001, 32'hB1B1_0001, 1'b1, 1'b1},
        '{32'h0400_0000, 32'h0000_0101, 3'd1, 1'b0, 32'h0,         1'b0, 32'h0,         32'hA1A1_0002, 32'hB1B1_0002, 1'b0, 1'b0},
        '{32'h0004_0000, 32'h0000_0101, 3'd2, 1'b0, 32'h0,         1'b0, 32'h0,         32'hA1A1_0003, 32'hB1B1_0003, 1'b0, 1'b0},
        '{32'hFFFF_0000, 32'hFFFF_0000, 3'd0, 1'b1, 32'h0000_3333, 1'b1, 32'h0000_4444, 32'hA1A1_0004, 32'hB1B1_0004, 1'b1, 1'b0},
        '{32'h0202_0000, 32'h0000_0300, 3'd1, 1'b0, 32'h0,         1'b0, 32'h0,         32'hA1A1_0005, 32'hB1B1_0005, 1'b1, 1'b0},
        '{32'h0202_0000, 32'h0000_0003, 3'd2, 1'b0, 32'h0,         1'b0, 32'h0,         32'hA1A1_0006, 32'hB1B1_0006, 1'b1, 1'b0},
        '{32'h0101_0000, 32'h0000_0505, 3'd3, 1'b1, 32'h5555_0000, 1'b0, 32'h0,         32'hA1A1_0007, 32'hB1B1_0007, 1'b1, 1'b1},
        '{32'h0303_0000, 32'h0000_FFFF, 3'd7, 1'b0, 32'h0,         1'b1, 32'h6666_0000, 32'hA1A1_0008, 32'hB1B1_0008, 1'b1, 1'b1}
    };

    int nvec = 0, nbad = 0;
    logic [31:0] exp_l = '0, exp_r = '0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic window(input int cycles);
        repeat (40) @(negedge clk);
        clr_gen++;
        repeat (cycles) @(negedge clk);
    endtask

    task automatic run_vec(input vec_t v, input int idx);
        tx_stat = v.wstat; rx_stat = v.rstat; lat = int'(v.lat); rd_l = v.rdl; rd_r = v.rdr;
        @(negedge clk);
        pl_left_data = v.lval;  pl_left_valid = v.push_l;
        pl_right_data = v.rval; pl_right_valid = v.push_r;
        @(negedge clk);
        pl_left_valid = 1'b0; pl_right_valid = 1'b0;
        if (v.push_l) exp_l = v.lval;
        if (v.push_r) exp_r = v.rval;
        window(160);
        chk((put_cnt > 0) == v.exp_put, $sformatf("R2 R9 vec%0d write gating", idx), 32'(put_cnt), {31'd0, v.exp_put});
        chk(order_err == 0, $sformatf("R3 vec%0d left-then-right order", idx), 32'(order_err), 32'd0);
        if (v.exp_put) begin
            chk(last_wl == exp_l, $sformatf("R4 vec%0d left value", idx), last_wl, exp_l);
            chk(last_wr == exp_r, $sformatf("R4 vec%0d right value", idx), last_wr, exp_r);
        end
        chk((cap_cnt > 0) == v.exp_cap, $sformatf("R5 vec%0d read gating", idx), 32'(cap_cnt), {31'd0, v.exp_cap});
        if (v.exp_cap) chk(last_cap == v.rdr, $sformatf("R6 vec%0d right sample forwarded", idx), last_cap, v.rdr);
        chk(timing_err == 0, $sformatf("R6 vec%0d strobe timing", idx), 32'(timing_err), 32'd0);
        chk(proto_err == 0, $sformatf("R7 vec%0d request held", idx), 32'(proto_err), 32'd0);
        chk(r8_err == 0, $sformatf("R8 vec%0d poll after read phase", idx), 32'(r8_err), 32'd0);
    endtask

    initial begin
        fork
            begin
                tx_stat = 32'h0101_0000; rx_stat = 32'h0;
                repeat (4) @(negedge clk);
                chk(!bus_rd && !bus_wr, "R1 no request in reset", {30'd0, bus_rd, bus_wr}, 32'd0);
                chk(!cap_valid, "R1 strobe low in reset", {31'd0, cap_valid}, 32'd0);
                rst = 1'b0;
                #1;
                chk(bus_rd && bus_addr == A_ST, "R1 first request is status read", {27'd0, bus_rd, bus_addr}, {27'd0, 1'b1, A_ST});
                window(100);
                chk(put_cnt > 0 && last_wl == 32'd0 && last_wr == 32'd0, "R4 reset value written",
                    last_wl | last_wr, 32'd0);
                chk(cap_cnt == 0, "R5 no input when counts zero", 32'(cap_cnt), 32'd0);
                for (int i = 0; i < 8; i++) run_vec(VECS[i], i);
                rst = 1'b1;
                @(negedge clk);
                chk(!bus_rd && !bus_wr && !cap_valid, "R1 reset mid-loop", {29'd0, bus_rd, bus_wr, cap_valid}, 32'd0);
            end
            begin
                repeat (100000) @(posedge clk);
                chk(1'b0, "R9 watchdog expired", 32'd1, 32'd0);
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule